// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block buffers executed stores between execution and retirement and lets later loads take their data straight from the youngest earlier store to the same address. Entries are kept in a circular buffer. Allocation happens in program order at the tail, and retirement happens in program order at the head. When an entry retires, its address and data appear on the commit outputs so that they can be written to memory.

A store is given its slot at allocation. It later fills in its address, data and a flag that records whether it hit in the L1 data cache. A load presents its address together with a slot pointer: the tail pointer value at the moment the load was placed in program order. Only entries between the head and that pointer are older than the load. The queue compares the load address against all of them in parallel and picks the youngest match. If that store hit in the L1 data cache, its data is forwarded. If it did not, the load is told to stall. If nothing matches, the load is sent to memory. The result is combinational and belongs to the cycle in which the load is presented.

Top module: `store_fwd_queue`

## Requirements
- R1: An allocation is accepted when the queue holds fewer than DEPTH entries and no flush is requested. The slot it returns is the current tail pointer, including its wrap bit, and the tail then advances by one. When DEPTH entries are held, allocation is refused, sqFull is 1 and the tail does not move.
- R2: A retire request is accepted when the queue is not empty. While the request is held, retireAddr and retireData show the head entry, and the head then advances by one. When the queue is empty, a retire request is refused.
- R3: An entry that has been allocated but not yet executed never matches a load.
- R4: A load treats an entry as older only when that entry's distance from the head is smaller than the distance of ldSlot from the head. Both distances are taken modulo 2*DEPTH.
- R5: When several older entries match, the one nearest to the load in program order supplies the forwarded data.
- R6: Data is forwarded only when the selected store has its L1-hit flag set. If the flag is clear, ldStall is 1 and both fwdValid and memRead are 0.
- R7: Matching compares the full address. Two addresses that are equal only in bits [11:0] do not match, and such a load goes to memory.
- R8: When no older executed entry matches, memRead is 1.
- R9: A flush moves the tail to the head as the head stands after any retire accepted in the same cycle. It invalidates every remaining entry, refuses an allocation in the same cycle, and leaves the queue empty in the following cycle.
- R10: While ldValid is 1, exactly one of fwdValid, memRead and ldStall is 1. While ldValid is 0, all three are 0.
- R11: The search result appears in the same cycle as the load inputs.
- R12: A retired store no longer matches any load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; empties the queue |
| allocValid | input | 1 | Request a new slot at the tail |
| allocAccept | output | 1 | Allocation taken this cycle |
| allocSlot | output | PTR_W | Slot pointer given to the new store (tail, with wrap bit) |
| execValid | input | 1 | A store writes its address and data |
| execSlot | input | IDX_W | Entry index of the executing store |
| execAddr | input | ADDR_W | Store address |
| execData | input | DATA_W | Store data |
| execL1Hit | input | 1 | Store hit in the L1 data cache |
| retireValid | input | 1 | Request retirement of the head entry |
| retireAccept | output | 1 | Retirement taken this cycle |
| retireAddr | output | ADDR_W | Address of the head entry, for commit |
| retireData | output | DATA_W | Data of the head entry, for commit |
| ldValid | input | 1 | A load searches the queue |
| ldAddr | input | ADDR_W | Load address |
| ldSlot | input | PTR_W | Tail pointer recorded when the load was placed in order |
| fwdValid | output | 1 | Data forwarded from a store |
| fwdData | output | DATA_W | Forwarded data (zero when fwdValid is 0) |
| memRead | output | 1 | Load must read the memory system |
| ldStall | output | 1 | Youngest older match was not an L1 hit; load must wait |
| flushValid | input | 1 | Discard all entries not yet retired |
| sqFull | output | 1 | DEPTH entries held |
| sqEmpty | output | 1 | No entries held |

## Verification
The bench builds the queue with DEPTH=4 and 16-bit addresses and data. This makes the pointers wrap after only a handful of allocations, so wrapped ordering is exercised without long runs. After every change to the queue, the bench sweeps every legal load slot position against a fixed set of addresses. That set includes a repeated address, an address never written, and an alias that differs only above bit 11. Each combination of age window, youngest-match selection and L1-hit gating is therefore compared against an arithmetic model of the queue. Filling to full, draining to empty, and a flush that coincides with a retire are all reached within a few dozen cycles.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef struct packed {
    logic alloc;
    logic retire;
    logic flush;
  } sqStrobe_t;
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH) + 1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             retireValid,
  input  logic             flushValid,
  output sqStrobe_t        strobe,
  output logic [PTR_W-1:0] headPtr,
  output logic [PTR_W-1:0] tailPtr,
  output logic             full,
  output logic             empty
);
  logic [PTR_W-1:0] headNext;

  assign empty = (headPtr == tailPtr);
  assign full  = (headPtr[IDX_W-1:0] == tailPtr[IDX_W-1:0]) &&
                 (headPtr[PTR_W-1] != tailPtr[PTR_W-1]);

  always_comb begin
    strobe.flush  = flushValid;
    strobe.retire = retireValid && !empty;
    strobe.alloc  = allocValid && !full && !flushValid;
  end

  assign headNext = strobe.retire ? headPtr + 1'b1 : headPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      headPtr <= headNext;
      if (strobe.flush)      tailPtr <= headNext;
      else if (strobe.alloc) tailPtr <= tailPtr + 1'b1;
    end
  end
endmodule

// File: rtl/sq_data.sv
module sq_data
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH) + 1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sqStrobe_t         strobe,
  input  logic [PTR_W-1:0]  headPtr,
  input  logic [PTR_W-1:0]  tailPtr,
  input  logic              execValid,
  input  logic [IDX_W-1:0]  execSlot,
  input  logic [ADDR_W-1:0] execAddr,
  input  logic [DATA_W-1:0] execData,
  input  logic              execL1Hit,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [PTR_W-1:0]  ldSlot,
  output logic [ADDR_W-1:0] retireAddr,
  output logic [DATA_W-1:0] retireData,
  output logic              fwdValid,
  output logic [DATA_W-1:0] fwdData,
  output logic              memRead,
  output logic              ldStall
);
  logic              addrValid [DEPTH];
  logic              l1Hit     [DEPTH];
  logic [ADDR_W-1:0] entryAddr [DEPTH];
  logic [DATA_W-1:0] entryData [DEPTH];
  logic [DEPTH-1:0]  matchVec;

  logic [IDX_W-1:0] headIdx, tailIdx, hitIdx;
  logic [PTR_W-1:0] occupancy, ldRel;
  logic             hit;

  assign headIdx   = headPtr[IDX_W-1:0];
  assign tailIdx   = tailPtr[IDX_W-1:0];
  assign occupancy = tailPtr - headPtr;
  assign ldRel     = ldSlot - headPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) addrValid[i] <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.flush) begin
          addrValid[i] <= 1'b0;
        end else begin
          if (strobe.retire && IDX_W'(i) == headIdx) addrValid[i] <= 1'b0;
          if (strobe.alloc && IDX_W'(i) == tailIdx)  addrValid[i] <= 1'b0;
          if (execValid && IDX_W'(i) == execSlot)    addrValid[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (execValid) begin
      entryAddr[execSlot] <= execAddr;
      entryData[execSlot] <= execData;
      l1Hit[execSlot]     <= execL1Hit;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cam
      logic [PTR_W-1:0] entryRel;
      assign entryRel    = {1'b0, IDX_W'(IDX_W'(g) - headIdx)};
      assign matchVec[g] = addrValid[g] && (entryAddr[g] == ldAddr) &&
                           (entryRel < ldRel) && (entryRel < occupancy);
    end
  endgenerate

  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (matchVec[IDX_W'(headIdx + IDX_W'(k))]) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(headIdx + IDX_W'(k));
      end
    end
  end

  assign fwdValid   = ldValid && hit && l1Hit[hitIdx];
  assign ldStall    = ldValid && hit && !l1Hit[hitIdx];
  assign memRead    = ldValid && !hit;
  assign fwdData    = fwdValid ? entryData[hitIdx] : '0;
  assign retireAddr = entryAddr[headIdx];
  assign retireData = entryData[headIdx];
endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH) + 1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  output logic              allocAccept,
  output logic [PTR_W-1:0]  allocSlot,
  input  logic              execValid,
  input  logic [IDX_W-1:0]  execSlot,
  input  logic [ADDR_W-1:0] execAddr,
  input  logic [DATA_W-1:0] execData,
  input  logic              execL1Hit,
  input  logic              retireValid,
  output logic              retireAccept,
  output logic [ADDR_W-1:0] retireAddr,
  output logic [DATA_W-1:0] retireData,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [PTR_W-1:0]  ldSlot,
  output logic              fwdValid,
  output logic [DATA_W-1:0] fwdData,
  output logic              memRead,
  output logic              ldStall,
  input  logic              flushValid,
  output logic              sqFull,
  output logic              sqEmpty
);
  sqStrobe_t        strobe;
  logic [PTR_W-1:0] headPtr, tailPtr;

  sq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .retireValid(retireValid),
    .flushValid(flushValid), .strobe(strobe), .headPtr(headPtr), .tailPtr(tailPtr),
    .full(sqFull), .empty(sqEmpty)
  );

  sq_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headPtr(headPtr), .tailPtr(tailPtr),
    .execValid(execValid), .execSlot(execSlot), .execAddr(execAddr),
    .execData(execData), .execL1Hit(execL1Hit), .ldValid(ldValid),
    .ldAddr(ldAddr), .ldSlot(ldSlot), .retireAddr(retireAddr),
    .retireData(retireData), .fwdValid(fwdValid), .fwdData(fwdData),
    .memRead(memRead), .ldStall(ldStall)
  );

  assign allocAccept  = strobe.alloc;
  assign retireAccept = strobe.retire;
  assign allocSlot    = tailPtr;
endmodule

// File: rtl/store_fwd_queue_checker.sv
module store_fwd_queue_checker #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             allocAccept,
  input logic [PTR_W-1:0] allocSlot,
  input logic             retireAccept,
  input logic             ldValid,
  input logic             fwdValid,
  input logic             memRead,
  input logic             ldStall,
  input logic             flushValid,
  input logic             sqFull,
  input logic             sqEmpty
);
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    sqFull |-> !allocAccept);

  p_tail_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    allocAccept |=> allocSlot == PTR_W'($past(allocSlot) + 1'b1));

  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    sqEmpty |-> !retireAccept);

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> sqEmpty);

  p_flush_blocks_alloc_r9: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> !allocAccept);

  p_one_result_r10: assert property (@(posedge clk) disable iff (!rstN)
    ldValid |-> $onehot({fwdValid, memRead, ldStall}));

  p_idle_result_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ldValid |-> $countones({fwdValid, memRead, ldStall}) == 0);

  p_full_empty_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(sqFull && sqEmpty));
endmodule

bind store_fwd_queue store_fwd_queue_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .allocAccept(allocAccept), .allocSlot(allocSlot),
  .retireAccept(retireAccept), .ldValid(ldValid), .fwdValid(fwdValid),
  .memRead(memRead), .ldStall(ldStall), .flushValid(flushValid),
  .sqFull(sqFull), .sqEmpty(sqEmpty)
);

// File: tb/store_fwd_queue_bench.sv
`timescale 1ns/1ps
module store_fwd_queue_bench;
  localparam int D = 4, AW = 16, DW = 16, PW = 3, IW = 2;

  logic clk = 0, rstN = 0;
  logic allocValid = 0, execValid = 0, execL1Hit = 0, retireValid = 0;
  logic ldValid = 0, flushValid = 0;
  logic [IW-1:0] execSlot = '0;
  logic [AW-1:0] execAddr = '0, ldAddr = '0;
  logic [DW-1:0] execData = '0;
  logic [PW-1:0] ldSlot = '0;
  logic allocAccept, retireAccept, fwdValid, memRead, ldStall, sqFull, sqEmpty;
  logic [PW-1:0] allocSlot;
  logic [AW-1:0] retireAddr;
  logic [DW-1:0] retireData, fwdData;

  int nChecks = 0, nFail = 0;
  int mHead = 0, mTail = 0;
  bit mExec [D];
  bit mL1 [D];
  int mAddr [D];
  int mData [D];
  int probeAddr [4] = '{'h0100, 'h0200, 'h1100, 'h0300};

  always #4 clk = ~clk;

  store_fwd_queue #(.DEPTH(D), .ADDR_W(AW), .DATA_W(DW)) u_store_fwd_queue (.*);

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int count();
    return (mTail - mHead + 2 * D) % (2 * D);
  endfunction

  task automatic doAlloc(bit expOk);
    allocValid = 1; #1;
    chk("R1 accept", allocAccept, expOk);
    chk("R1 full flag", sqFull, count() == D);
    if (expOk) chk("R1 slot", allocSlot, mTail);
    @(posedge clk);
    if (expOk) begin mExec[mTail % D] = 0; mTail = (mTail + 1) % (2 * D); end
    @(negedge clk); allocValid = 0;
  endtask

  task automatic doExec(int slot, int a, int d, bit l1);
    execValid = 1; execSlot = IW'(slot); execAddr = AW'(a); execData = DW'(d); execL1Hit = l1;
    @(posedge clk);
    mExec[slot] = 1; mAddr[slot] = a; mData[slot] = d; mL1[slot] = l1;
    @(negedge clk); execValid = 0;
  endtask

  task automatic doRetire(bit expOk);
    retireValid = 1; #1;
    chk("R2 accept", retireAccept, expOk);
    if (expOk) begin
      chk("R2 commit addr", retireAddr, mAddr[mHead % D]);
      chk("R2 commit data", retireData, mData[mHead % D]);
    end
    @(posedge clk);
    if (expOk) begin mExec[mHead % D] = 0; mHead = (mHead + 1) % (2 * D); end
    @(negedge clk); retireValid = 0;
  endtask

  // Every legal load slot against every probe address; tag names the scenario.
  task automatic sweep(string tag);
    for (int s = 0; s <= count(); s++) begin
      for (int p = 0; p < 4; p++) begin
        int hitSlot = -1;
        for (int k = 0; k < s; k++) begin
          int idx = (mHead + k) % D;
          if (mExec[idx] && mAddr[idx] == probeAddr[p]) hitSlot = idx;
        end
        ldValid = 1; ldAddr = AW'(probeAddr[p]); ldSlot = PW'((mHead + s) % (2 * D));
        #1;
        chk({tag, " R4 R8 memRead"}, memRead, hitSlot < 0);
        chk({tag, " R5 fwdValid"}, fwdValid, hitSlot >= 0 && mL1[hitSlot]);
        chk({tag, " R6 ldStall"}, ldStall, hitSlot >= 0 && !mL1[hitSlot]);
        if (hitSlot >= 0 && mL1[hitSlot]) chk({tag, " R5 R11 fwdData"}, fwdData, mData[hitSlot]);
        chk({tag, " R10 one result"}, $countones({fwdValid, memRead, ldStall}), 1);
      end
    end
    ldValid = 0; #1;
    chk({tag, " R10 idle"}, {fwdValid, memRead, ldStall}, 0);
  endtask

  initial begin
    #(8 * 100000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) begin mExec[i] = 0; mL1[i] = 0; mAddr[i] = 0; mData[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R2 reset empty", sqEmpty, 1);
    chk("R1 reset not full", sqFull, 0);
    sweep("R8 reset");
    doRetire(0);

    for (int i = 0; i < D; i++) doAlloc(1);
    doAlloc(0);
    sweep("R3 unexecuted");
    doExec(0, 'h0100, 'hA000, 1); sweep("R4 one store");
    doExec(1, 'h0200, 'hA001, 1); sweep("R4 two stores");
    doExec(2, 'h0100, 'hA002, 1); sweep("R5 repeat addr");
    doExec(3, 'h0100, 'hA003, 0); sweep("R6 non-L1 youngest");
    sweep("R7 alias");

    doRetire(1); sweep("R12 after retire");
    doRetire(1); sweep("R12 after two retires");
    doAlloc(1); doAlloc(1);
    doExec(0, 'h1100, 'hB000, 1);
    doExec(1, 'h0200, 'hB001, 1);
    sweep("R4 wrapped");
    doAlloc(0);

    flushValid = 1; retireValid = 1; #1;
    chk("R9 retire with flush", retireAccept, 1);
    @(posedge clk);
    mHead = (mHead + 1) % (2 * D); mTail = mHead;
    for (int i = 0; i < D; i++) mExec[i] = 0;
    @(negedge clk); flushValid = 0; retireValid = 0;
    chk("R9 empty after flush", sqEmpty, 1);
    sweep("R9 flushed");
    doAlloc(1);
    doExec(mHead % D, 'h0300, 'hC000, 1);
    sweep("R9 reuse");
    doRetire(1);
    doRetire(0);
    chk("R2 drained", sqEmpty, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule